// File: doc/BRIEF.md
# Interrupt Flag Aggregation Controller

This block gathers the event indications of a contactless reader core into one 8-bit flag word and drives a single interrupt pin. Seven flags are latched from one-cycle pulses: timer expiry, transmit done, CRC done, receive done, command idle, FIFO almost full and FIFO almost empty. The timer's pulse marks its counter stepping from 1 to 0. The CRC pulse marks that the CRC unit has consumed all FIFO data. A latched flag stays set until the host clears it, and the host can also set it.

The eighth flag is the error flag. It is not latched. It reads as 1 whenever any bit of a separate error register is 1. That register collects error pulses and is cleared by write-1-to-clear.

A per-flag enable mask decides which flags reach the pin, and a polarity bit selects active-high or active-low signalling. The host reaches all of this through a single-cycle write strobe and a combinational read port over four addresses.

Top module: `irq_aggr`

## Requirements
- R1: After reset, the flag word, enable mask, polarity bit and error register all read 0, and `irq_o` is 0.
- R2: A pulse on `evt_i[k]` (k in 0..6) sets flag bit k from the next cycle. The flag then holds until the host clears it. Flag bits are: 0 timer, 1 transmit, 2 CRC, 3 receive, 4 idle, 5 FIFO almost full, 6 FIFO almost empty, 7 error.
- R3: A write to address 0 with data bit 7 = 1 sets every flag marked by a 1 in data bits 6:0. All other flags are left unchanged.
- R4: A write to address 0 with data bit 7 = 0 clears every flag marked by a 1 in data bits 6:0. All other flags are left unchanged.
- R5: When a source pulse and a host clear hit the same flag in the same cycle, the flag is set after that cycle.
- R6: Flag bit 7 reads 1 exactly when the error register is non-zero. No write to address 0 changes it.
- R7: A pulse on `err_evt_i[j]` sets error register bit j. A write to address 3 clears the bits written as 1. In the same cycle, a pulse takes priority over the clear.
- R8: `irq_o` equals the OR over all eight bits of (flag AND enable). Polarity bit 1 (address 2, bit 0) inverts it to active-low.
- R9: Address 1 holds the enable mask, written and read as a full byte. Address 2 reads the polarity in bit 0 and zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 7 | One-cycle source pulses for flags 6:0 |
| err_evt_i | input | 8 | One-cycle error pulses for the error register |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 flags, 1 enable, 2 polarity, 3 error |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt pin |

## Verification
Several checks run on every cycle:
- each latched flag rises after its pulse, including when a host clear arrives in the same cycle;
- a clear with no competing pulse drops the flag;
- error bits follow the same set and clear rules;
- the readable error flag always matches the error register;
- an enable write lands in the mask;
- the pin holds still while flags, mask and polarity hold still.

Two things need the bench's scenarios against its reference model: that unmarked flags survive set and clear writes untouched, and the exact pin level under both polarities for a given flag and mask mix.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;
  localparam int NFLAG    = 8;
  localparam int NSRC     = NFLAG - 1;
  localparam int FLAG_ERR = NFLAG - 1;
  localparam int DW       = 8;

  typedef enum logic [1:0] {
    REG_FLAG = 2'd0,
    REG_EN   = 2'd1,
    REG_CFG  = 2'd2,
    REG_ERR  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NSRC = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic            wr_i,
  input  logic            set_sel_i,
  input  logic [NSRC-1:0] mask_i,
  output logic [NSRC-1:0] flag_o
);
  for (genvar k = 0; k < NSRC; k++) begin : g_flag
    logic host_set, host_clr, q;

    assign host_set = wr_i & set_sel_i & mask_i[k];
    assign host_clr = wr_i & ~set_sel_i & mask_i[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= evt_i[k] | host_set | (q & ~host_clr);
    end
    assign flag_o[k] = q;

    // R2 R5
    src_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[k] |=> flag_o[k]);

    // R3
    host_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && set_sel_i && mask_i[k]) |=> flag_o[k]);

    // R4
    host_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !set_sel_i && mask_i[k] && !evt_i[k]) |=> !flag_o[k]);
  end
endmodule

// File: rtl/irq_err_reg.sv
module irq_err_reg #(
  parameter int ERR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ERR_W-1:0] evt_i,
  input  logic             w1c_i,
  input  logic [ERR_W-1:0] mask_i,
  output logic [ERR_W-1:0] q_o
);
  for (genvar j = 0; j < ERR_W; j++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= evt_i[j] | (q & ~(w1c_i & mask_i[j]));
    end
    assign q_o[j] = q;

    // R7
    err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[j] |=> q_o[j]);

    // R7
    err_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (w1c_i && mask_i[j] && !evt_i[j]) |=> !q_o[j]);
  end
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv #(
  parameter int NFLAG = 8
) (
  input  logic [NFLAG-1:0] flag_i,
  input  logic [NFLAG-1:0] en_i,
  input  logic             low_act_i,
  output logic             irq_o
);
  logic any_act;
  assign any_act = |(flag_i & en_i);
  assign irq_o   = low_act_i ? ~any_act : any_act;
endmodule

// File: rtl/irq_aggr.sv
module irq_aggr
  import irq_aggr_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  evt_i,
  input  logic [ERR_W-1:0] err_evt_i,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             irq_o
);
  localparam int PAD_W = DW - ERR_W;

  logic [NSRC-1:0]  src_flag;
  logic [NFLAG-1:0] flag_word;
  logic [NFLAG-1:0] en_q;
  logic             pol_q;
  logic [ERR_W-1:0] err_q;
  logic             wr_flag, wr_en, wr_cfg, wr_err;

  assign wr_flag = we_i && (addr_i == REG_FLAG);
  assign wr_en   = we_i && (addr_i == REG_EN);
  assign wr_cfg  = we_i && (addr_i == REG_CFG);
  assign wr_err  = we_i && (addr_i == REG_ERR);

  irq_flag_bank #(.NSRC(NSRC)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_i),
    .wr_i      (wr_flag),
    .set_sel_i (wdata_i[DW-1]),
    .mask_i    (wdata_i[NSRC-1:0]),
    .flag_o    (src_flag)
  );

  irq_err_reg #(.ERR_W(ERR_W)) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (err_evt_i),
    .w1c_i  (wr_err),
    .mask_i (wdata_i[ERR_W-1:0]),
    .q_o    (err_q)
  );

  assign flag_word = {|err_q, src_flag};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      pol_q <= 1'b0;
    end else begin
      if (wr_en)  en_q  <= wdata_i[NFLAG-1:0];
      if (wr_cfg) pol_q <= wdata_i[0];
    end
  end

  irq_pin_drv #(.NFLAG(NFLAG)) u_pin (
    .flag_i    (flag_word),
    .en_i      (en_q),
    .low_act_i (pol_q),
    .irq_o     (irq_o)
  );

  always_comb begin
    unique case (addr_i)
      REG_FLAG: rdata_o = flag_word;
      REG_EN:   rdata_o = en_q;
      REG_CFG:  rdata_o = {{(DW-1){1'b0}}, pol_q};
      default:  rdata_o = {{PAD_W{1'b0}}, err_q};
    endcase
  end

  // R6
  err_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_FLAG) |-> (rdata_o[FLAG_ERR] == (err_q != '0)));

  // R9
  en_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> (en_q == $past(wdata_i)));

  // R8
  irq_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(flag_word) && $stable(en_q) && $stable(pol_q)) |-> $stable(irq_o));
endmodule

// File: tb/irq_aggr_tb.sv
module irq_aggr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] evt_i = '0;
  logic [7:0] err_evt_i = '0;
  logic       we_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [6:0] m_flag;
  logic [7:0] m_en, m_err;
  logic       m_pol;

  irq_aggr u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return {|m_err, m_flag};
      2'd1: return m_en;
      2'd2: return {7'b0, m_pol};
      default: return m_err;
    endcase
  endfunction

  function automatic logic exp_irq();
    logic any;
    any = |({|m_err, m_flag} & m_en);
    return m_pol ? ~any : any;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // drive one cycle, check current state through addr a, then update model at the edge
  task automatic cyc(input string tag, input logic we, input logic [1:0] a,
                     input logic [7:0] wd, input logic [6:0] ev, input logic [7:0] ee);
    @(negedge clk_i);
    we_i = we; addr_i = a; wdata_i = wd; evt_i = ev; err_evt_i = ee;
    #1;
    chk(tag, rdata_o, exp_read(a));
    chk({tag, "_irq"}, {7'b0, irq_o}, {7'b0, exp_irq()});
    @(posedge clk_i);
    if (we && a == 2'd0) begin
      if (wd[7]) m_flag = m_flag | wd[6:0];
      else       m_flag = m_flag & ~wd[6:0];
    end
    m_flag = m_flag | ev;
    if (we && a == 2'd1) m_en = wd;
    if (we && a == 2'd2) m_pol = wd[0];
    if (we && a == 2'd3) m_err = m_err & ~wd;
    m_err = m_err | ee;
  endtask

  task automatic rd(input string tag, input logic [1:0] a);
    cyc(tag, 1'b0, a, 8'h00, 7'h00, 8'h00);
  endtask

  initial begin
    int unsigned seed;
    logic [7:0] r;
    seed = 32'd1234;
    r = 8'($urandom(seed));
    m_flag = '0; m_en = '0; m_err = '0; m_pol = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1 reset state
    rd("R1", 2'd0); rd("R1", 2'd1); rd("R1", 2'd2); rd("R1", 2'd3);

    // R2 source pulses latch and hold
    cyc("R2", 1'b0, 2'd0, 8'h00, 7'h01, 8'h00);
    rd("R2", 2'd0); rd("R2", 2'd0);
    cyc("R2", 1'b0, 2'd0, 8'h00, 7'h48, 8'h00);
    rd("R2", 2'd0);

    // R3 set marked flags only
    cyc("R3", 1'b1, 2'd0, 8'h86, 7'h00, 8'h00);
    rd("R3", 2'd0);

    // R4 clear marked flags only
    cyc("R4", 1'b1, 2'd0, 8'h05, 7'h00, 8'h00);
    rd("R4", 2'd0);

    // R5 pulse beats clear
    cyc("R5", 1'b1, 2'd0, 8'h7F, 7'h10, 8'h00);
    rd("R5", 2'd0);

    // R6 error flag follows error register, not writable through address 0
    cyc("R6", 1'b1, 2'd0, 8'hFF, 7'h00, 8'h00);
    rd("R6", 2'd0);
    cyc("R6", 1'b0, 2'd0, 8'h00, 7'h00, 8'h24);
    rd("R6", 2'd0);
    cyc("R6", 1'b1, 2'd0, 8'h7F, 7'h00, 8'h00);
    rd("R6", 2'd0);

    // R7 W1C and pulse priority
    cyc("R7", 1'b1, 2'd3, 8'h04, 7'h00, 8'h00);
    rd("R7", 2'd3);
    cyc("R7", 1'b1, 2'd3, 8'h20, 7'h00, 8'h20);
    rd("R7", 2'd3);
    cyc("R7", 1'b1, 2'd3, 8'hFF, 7'h00, 8'h00);
    rd("R7", 2'd3); rd("R6", 2'd0);

    // R9 enable and polarity access
    cyc("R9", 1'b1, 2'd1, 8'hA5, 7'h00, 8'h00);
    rd("R9", 2'd1);
    cyc("R9", 1'b1, 2'd2, 8'hFF, 7'h00, 8'h00);
    rd("R9", 2'd2);

    // R8 masking and polarity
    cyc("R8", 1'b1, 2'd2, 8'h00, 7'h00, 8'h00);
    cyc("R8", 1'b1, 2'd0, 8'h7F, 7'h00, 8'h00);
    cyc("R8", 1'b1, 2'd1, 8'h00, 7'h00, 8'h00);
    rd("R8", 2'd0);
    cyc("R8", 1'b1, 2'd1, 8'h80, 7'h00, 8'h00);
    rd("R8", 2'd1);
    cyc("R8", 1'b0, 2'd1, 8'h00, 7'h00, 8'h01);
    rd("R8", 2'd1);
    cyc("R8", 1'b1, 2'd2, 8'h01, 7'h00, 8'h00);
    rd("R8", 2'd2);
    cyc("R8", 1'b1, 2'd3, 8'hFF, 7'h00, 8'h00);
    rd("R8", 2'd2);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic w;
      logic [1:0] a;
      logic [7:0] d;
      logic [6:0] ev;
      logic [7:0] ee;
      w  = ($urandom % 3) == 0;
      a  = 2'($urandom);
      d  = 8'($urandom);
      ev = (($urandom % 4) == 0) ? 7'(1 << ($urandom % 7)) : 7'h00;
      ee = (($urandom % 8) == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
      cyc("RND", w, a, d, ev, ee);
    end

    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule